// File: doc/BRIEF.md
# Lane-Sparing Retry Link Layer

This block is the link layer for one direction of a port built from 20 parallel serial lanes. Every beat sends 18 data bits, a parity bit and one spare lane. On the transmit side, accepted words go into a 16-entry replay store. Each beat sent on the wire gets an even-parity bit across its data bits. If a lane has been swapped out, a copy of that lane's logical bit is also placed on the spare lane. The receive side removes the lane swap, checks parity and delivers good words in order. A full-duplex port uses two instances of this block, one for each direction.

When the receiver finds a parity error, it drops that beat and every data beat after it. A retry request then travels back through a delay line that models the reverse path. The delay line also carries the cumulative acknowledge. When the transmitter sees the request, it sends an 8-beat lane-test pattern and then replays from the first word that was not delivered. The receiver compares every lane with the pattern during the test. If exactly one lane fails and no lane is yet swapped, that lane is moved onto the spare from the first beat after the test. Any other failure makes the link fatal. Saturating counters record the number of retries and the number of lane swaps.

Top module: `lrcLink`

## Requirements
- R1: `txKind` uses 0 for idle, 1 for data and 2 for lane-test. On a data beat, lanes 0 to 17 carry data bits 0 to 17 and lane 18 carries the XOR of those 18 bits. Lane 19 is 0 while no lane is swapped.
- R2: Words are delivered on `rxData`/`rxValid` in the order they were accepted, with no loss and no duplicates, for any number of retries. A word is delivered at the clock edge that samples its good beat.
- R3: A data beat with an odd number of corrupted lanes is discarded, together with every later data beat, until the lane test has finished. Each retry increments `retryCount`.
- R4: A retry sends exactly 8 lane-test beats, numbered k = 0 to 7. On beat k, lane i carries i[0] XOR k[0].
- R5: A test in which exactly one of lanes 0 to 18 fails, with no lane yet swapped, writes that lane's index into `remapLane` and increments `remapCount`. From the next beat on, lane 19 carries that lane's logical bit, and the receiver reads the bit from lane 19.
- R6: `remapLane` is 31 when no lane is swapped. It stays 31 after tests in which no lane fails.
- R7: A test in which more than one lane fails sets `linkFatal`, and the flag stays set until reset. While fatal, `rxValid` is 0, `inReady` is 0 and `txKind` is idle.
- R8: Once a lane is swapped, a failure on any other lane during a test sets `linkFatal`, and `remapLane` keeps its value.
- R9: At most 16 words can be held unacknowledged. `inReady` is 0 while 16 are outstanding.
- R10: `retryCount` and `remapCount` saturate at 2^CNT_W-1.
- R11: After reset, `rxValid`=0, `inReady`=1, `txKind`=0, `linkFatal`=0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Word offered for sending |
| inData | input | 18 | Word to send |
| inReady | output | 1 | Word is accepted this cycle |
| txLanes | output | 20 | Physical lanes driven toward the far end |
| txKind | output | 2 | Beat type on the wire (0 idle, 1 data, 2 test) |
| rxLanes | input | 20 | Physical lanes received, in the same cycle |
| rxValid | output | 1 | Delivered word is valid |
| rxData | output | 18 | Delivered word |
| remapLane | output | 5 | Logical lane moved onto the spare; 31 means none |
| linkFatal | output | 1 | Sticky unrecoverable link error |
| retryCount | output | CNT_W | Saturating number of retries |
| remapCount | output | CNT_W | Saturating number of lane swaps |

## Verification
The properties and the sequencing assume the following about the inputs:
- `rxLanes` is `txLanes` passed through in the same cycle.
- A fault present while the test pattern runs is permanent.
- An intermittent upset flips an odd number of lanes on a data beat.

The bench keeps to these assumptions. Stuck-at faults are applied before a retry and held steady. Bit flips last one cycle, are placed only on data beats, and are spaced far enough apart that each retry and its replay finish first. The one test that uses two simultaneous stuck lanes does not check the delivered data, because an even number of bad lanes can pass parity.

// File: rtl/lrcPkg.sv
package lrcPkg;
  localparam int DATA_LANES = 18;
  localparam int LOG_LANES  = DATA_LANES + 1;
  localparam int PHY_LANES  = LOG_LANES + 1;
  localparam int SPARE_LANE = PHY_LANES - 1;
  localparam int BUF_DEPTH  = 16;
  localparam int IDX_W      = $clog2(BUF_DEPTH);
  localparam int SEQ_W      = IDX_W + 1;
  localparam int TEST_BEATS = 8;
  localparam int TCNT_W     = $clog2(TEST_BEATS);
  localparam int LANE_W     = 5;
  localparam logic [LANE_W-1:0] NO_REMAP = '1;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_TEST = 2'd2
  } beatKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              bufWr;
    logic [IDX_W-1:0]  wrIdx;
    logic [IDX_W-1:0]  rdIdx;
    beatKind_e         kind;
    logic [TCNT_W-1:0] testIdx;
    logic [LANE_W-1:0] remap;
    logic              deliver;
  } linkStrobe_t;
endpackage

// File: rtl/lrcDatapath.sv
module lrcDatapath
  import lrcPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  linkStrobe_t           st,
  input  logic [DATA_LANES-1:0] inData,
  input  logic [PHY_LANES-1:0]  rxLanes,
  output logic [PHY_LANES-1:0]  txLanes,
  output logic                  parityOk,
  output logic [PHY_LANES-1:0]  failVec,
  output logic                  rxValid,
  output logic [DATA_LANES-1:0] rxData
);
  logic [DATA_LANES-1:0] replayMem [BUF_DEPTH];
  logic [LOG_LANES-1:0]  txLogical;
  logic [LOG_LANES-1:0]  rxLogical;
  logic [PHY_LANES-1:0]  testPat;
  logic                  remapOn;

  assign remapOn = st.remap < LANE_W'(LOG_LANES);

  always_ff @(posedge clk) begin
    if (st.bufWr) replayMem[st.wrIdx] <= inData;
  end

  assign txLogical = {^replayMem[st.rdIdx], replayMem[st.rdIdx]};

  // alternating test pattern, phase flips every beat
  for (genvar g = 0; g < PHY_LANES; g++) begin : g_pat
    assign testPat[g] = 1'(g % 2) ^ st.testIdx[0];
  end

  // receiver: undo the spare steering
  for (genvar g = 0; g < LOG_LANES; g++) begin : g_unmap
    assign rxLogical[g] = (remapOn && st.remap == LANE_W'(g)) ? rxLanes[SPARE_LANE] : rxLanes[g];
  end

  always_comb begin
    txLanes = '0;
    case (st.kind)
      KIND_DATA: begin
        txLanes[LOG_LANES-1:0] = txLogical;
        if (remapOn) txLanes[SPARE_LANE] = txLogical[st.remap];
      end
      KIND_TEST: txLanes = testPat;
      default:   txLanes = '0;
    endcase
  end

  assign parityOk = ~^rxLogical;
  assign failVec  = rxLanes ^ testPat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= st.deliver;
      if (st.deliver) rxData <= rxLogical[DATA_LANES-1:0];
    end
  end
endmodule

// File: rtl/lrcControl.sv
module lrcControl
  import lrcPkg::*;
#(
  parameter int REV_DELAY = 4,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 parityOk,
  input  logic [PHY_LANES-1:0] failVec,
  output linkStrobe_t          st,
  output logic                 inReady,
  output logic                 linkFatal,
  output logic [LANE_W-1:0]    remapLane,
  output logic [CNT_W-1:0]     retryCount,
  output logic [CNT_W-1:0]     remapCount
);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [TCNT_W-1:0] LAST_TEST = TCNT_W'(TEST_BEATS - 1);

  logic [SEQ_W-1:0]     wrPtr, rdPtr, rxExp, ackPtr, unacked;
  logic                 testMode, dropMode, retryBack;
  logic [TCNT_W-1:0]    testIdx;
  logic [PHY_LANES-1:0] failAcc, failsNow, failsMasked;
  logic [REV_DELAY-1:0] revRetry;
  logic [SEQ_W-1:0]     revSeq [REV_DELAY];
  logic                 sendData, accept, goodBeat, badBeat, lastTest, newRemap, goFatal;
  logic [LANE_W-1:0]    failIdx, failNum;

  assign ackPtr    = revSeq[REV_DELAY-1];
  assign retryBack = revRetry[REV_DELAY-1];
  assign unacked   = wrPtr - ackPtr;
  assign inReady   = !unacked[SEQ_W-1] && !linkFatal;
  assign accept    = inValid && inReady;
  assign sendData  = !linkFatal && !testMode && (rdPtr != wrPtr);
  assign goodBeat  = sendData && !dropMode && parityOk;
  assign badBeat   = sendData && !dropMode && !parityOk;
  assign lastTest  = testMode && (testIdx == LAST_TEST);

  // lane-test verdict, including the current beat
  always_comb begin
    failsNow    = failAcc | failVec;
    failsMasked = failsNow;
    if (remapLane == NO_REMAP) begin
      failsMasked[SPARE_LANE] = 1'b0;
    end else begin
      for (int i = 0; i < LOG_LANES; i++)
        if (LANE_W'(i) == remapLane) failsMasked[i] = 1'b0;
    end
    failNum = '0;
    failIdx = '0;
    for (int i = PHY_LANES - 1; i >= 0; i--) begin
      if (failsMasked[i]) begin
        failNum = failNum + 1'b1;
        failIdx = LANE_W'(i);
      end
    end
    newRemap = (remapLane == NO_REMAP) && (failNum == LANE_W'(1));
    goFatal  = (failNum != '0) && !newRemap;
  end

  always_comb begin
    st.bufWr   = accept;
    st.wrIdx   = wrPtr[IDX_W-1:0];
    st.rdIdx   = rdPtr[IDX_W-1:0];
    st.testIdx = testIdx;
    st.remap   = remapLane;
    st.deliver = goodBeat;
    if (linkFatal)     st.kind = KIND_IDLE;
    else if (testMode) st.kind = KIND_TEST;
    else if (sendData) st.kind = KIND_DATA;
    else               st.kind = KIND_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      rxExp      <= '0;
      testMode   <= 1'b0;
      dropMode   <= 1'b0;
      testIdx    <= '0;
      failAcc    <= '0;
      revRetry   <= '0;
      for (int i = 0; i < REV_DELAY; i++) revSeq[i] <= '0;
      remapLane  <= NO_REMAP;
      linkFatal  <= 1'b0;
      retryCount <= '0;
      remapCount <= '0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;

      if (retryBack && !testMode && !linkFatal) begin
        testMode <= 1'b1;
        testIdx  <= '0;
        failAcc  <= '0;
        rdPtr    <= ackPtr;
        if (retryCount != CNT_MAX) retryCount <= retryCount + 1'b1;
      end else if (sendData) begin
        rdPtr <= rdPtr + 1'b1;
      end

      if (testMode) begin
        testIdx <= testIdx + 1'b1;
        failAcc <= failsNow;
        if (lastTest) begin
          testMode <= 1'b0;
          dropMode <= 1'b0;
          if (goFatal) begin
            linkFatal <= 1'b1;
          end else if (newRemap) begin
            remapLane <= failIdx;
            if (remapCount != CNT_MAX) remapCount <= remapCount + 1'b1;
          end
        end
      end

      if (goodBeat) rxExp <= rxExp + 1'b1;
      if (badBeat)  dropMode <= 1'b1;

      // reverse path: retry flag with cumulative acknowledge
      revRetry[0] <= badBeat;
      revSeq[0]   <= rxExp;
      for (int i = 1; i < REV_DELAY; i++) begin
        revRetry[i] <= revRetry[i-1];
        revSeq[i]   <= revSeq[i-1];
      end
    end
  end
endmodule

// File: rtl/lrcLink.sv
module lrcLink
  import lrcPkg::*;
#(
  parameter int REV_DELAY = 4,
  parameter int CNT_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [DATA_LANES-1:0] inData,
  output logic                  inReady,
  output logic [PHY_LANES-1:0]  txLanes,
  output logic [1:0]            txKind,
  input  logic [PHY_LANES-1:0]  rxLanes,
  output logic                  rxValid,
  output logic [DATA_LANES-1:0] rxData,
  output logic [LANE_W-1:0]     remapLane,
  output logic                  linkFatal,
  output logic [CNT_W-1:0]      retryCount,
  output logic [CNT_W-1:0]      remapCount
);
  linkStrobe_t          st;
  logic                 parityOk;
  logic [PHY_LANES-1:0] failVec;

  assign txKind = st.kind;

  lrcControl #(.REV_DELAY(REV_DELAY), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .parityOk(parityOk), .failVec(failVec),
    .st(st), .inReady(inReady), .linkFatal(linkFatal), .remapLane(remapLane),
    .retryCount(retryCount), .remapCount(remapCount)
  );

  lrcDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .rxLanes(rxLanes),
    .txLanes(txLanes), .parityOk(parityOk), .failVec(failVec),
    .rxValid(rxValid), .rxData(rxData)
  );
endmodule

// File: rtl/lrcChecker.sv
module lrcChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             linkFatal,
  input logic             rxValid,
  input logic             inReady,
  input logic [1:0]       txKind,
  input logic [4:0]       remapLane,
  input logic [CNT_W-1:0] retryCount,
  input logic [CNT_W-1:0] remapCount
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r7_fatal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    linkFatal |=> linkFatal);

  a_r7_fatal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    linkFatal |=> (!rxValid && !inReady && txKind == 2'd0));

  a_r6_remap_once: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remapLane) |-> ($past(remapLane) == 5'd31 && remapLane <= 5'd18));

  a_r5_count_follows_remap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remapCount) |-> !$stable(remapLane));

  a_r10_retry_monotone: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> retryCount >= $past(retryCount));

  a_r10_retry_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (retryCount == CMAX) |=> (retryCount == CMAX));

  a_r9_test_no_accept_when_fatal: assert property (@(posedge clk) disable iff (!rstN)
    linkFatal |-> !inReady);
endmodule

bind lrcLink lrcChecker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .linkFatal(linkFatal), .rxValid(rxValid), .inReady(inReady),
  .txKind(txKind), .remapLane(remapLane), .retryCount(retryCount), .remapCount(remapCount)
);

// File: tb/test_lrcLink.sv
module test_lrcLink;
  localparam int CLK_PERIOD = 10;
  localparam int REV = 20;
  localparam int CW  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [17:0] inData = '0;
  logic        inReady;
  logic [19:0] txLanes, rxLanes;
  logic [1:0]  txKind;
  logic        rxValid;
  logic [17:0] rxData;
  logic [4:0]  remapLane;
  logic        linkFatal;
  logic [CW-1:0] retryCount, remapCount;

  logic [19:0] stuck1 = '0, stuck0 = '0, flip = '0;
  assign rxLanes = ((txLanes | stuck1) & ~stuck0) ^ flip;

  int checks = 0, failures = 0;
  int sent = 0, expIdx = 0, testRun = 0;
  bit pendAcc = 0, feedEn = 0, monOn = 1, sawStall = 0;

  lrcLink #(.REV_DELAY(REV), .CNT_W(CW)) i_lrcLink (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .txLanes(txLanes), .txKind(txKind), .rxLanes(rxLanes), .rxValid(rxValid),
    .rxData(rxData), .remapLane(remapLane), .linkFatal(linkFatal),
    .retryCount(retryCount), .remapCount(remapCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] wordOf(int n);
    logic [31:0] v;
    v = n * 32'h9E37 + (n >> 3) * 32'h1F;
    return v[17:0] ^ v[27:10];
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and word feeder
  always @(negedge clk) begin
    if (!rstN) begin
      sent = 0; expIdx = 0; pendAcc = 0; testRun = 0; inValid = 0;
    end else begin
      if (pendAcc) sent++;
      if (rxValid) begin
        if (monOn) check(rxData == wordOf(expIdx), "R2 in-order delivery", rxData, wordOf(expIdx));
        expIdx++;
      end
      if (monOn) check(sent - expIdx <= 16, "R9 outstanding bound", sent - expIdx, 16);
      if (feedEn && !inReady && !linkFatal) sawStall = 1;
      if (txKind == 2'd1) begin
        check(txLanes[18] == ^txLanes[17:0], "R1 parity lane", txLanes[18], ^txLanes[17:0]);
        if (remapLane == 5'd31) check(txLanes[19] == 1'b0, "R1 spare idle", txLanes[19], 0);
        else check(txLanes[19] == txLanes[remapLane], "R5 spare copy", txLanes[19], txLanes[remapLane]);
      end
      if (txKind == 2'd2) begin
        check(txLanes == ((testRun % 2) ? 20'h55555 : 20'hAAAAA), "R4 test pattern",
              txLanes, (testRun % 2) ? 20'h55555 : 20'hAAAAA);
        testRun++;
      end else begin
        if (testRun != 0) check(testRun == 8, "R4 test length", testRun, 8);
        testRun = 0;
      end
      inValid = feedEn;
      inData  = wordOf(sent);
      pendAcc = inValid && inReady;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    tick(1);
    rstN = 0; feedEn = 0; stuck0 = '0; stuck1 = '0; flip = '0;
    tick(3);
    rstN = 1;
    tick(1);
  endtask

  task automatic drain(string tag);
    feedEn = 0;
    tick(80);
    check(expIdx == sent, tag, expIdx, sent);
  endtask

  task automatic inject(logic [19:0] mask);
    for (int w = 0; w < 1000 && txKind != 2'd1; w++) tick(1);
    flip = mask;
    tick(1);
    flip = '0;
  endtask

  task automatic waitFor(bit which);
    for (int w = 0; w < 600; w++) begin
      if (which ? linkFatal : (remapLane != 5'd31)) break;
      tick(1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1;
    tick(1);
    // R11 reset state, R6 idle remap code
    check(rxValid == 0, "R11 rxValid", rxValid, 0);
    check(inReady == 1, "R11 inReady", inReady, 1);
    check(txKind == 0, "R11 txKind", txKind, 0);
    check(linkFatal == 0, "R11 fatal", linkFatal, 0);
    check(retryCount == 0 && remapCount == 0, "R11 counters", {retryCount, remapCount}, 0);
    check(remapLane == 5'd31, "R6 reset code", remapLane, 31);

    // clean stream with backpressure from slow acknowledge
    feedEn = 1;
    tick(400);
    drain("R2 clean drain");
    check(sawStall, "R9 stall seen", sawStall, 1);
    check(sent > 100, "R2 traffic moved", sent, 100);
    check(retryCount == 0, "R3 no retry on clean link", retryCount, 0);

    // intermittent upsets, one and three lanes
    doReset();
    feedEn = 1;
    tick(10);
    for (int k = 1; k <= 9; k++) begin
      inject((k % 2) ? 20'h00010 : 20'h00421);
      tick(90);
      check(retryCount == ((k < 7) ? k : 7), (k <= 7) ? "R3 retry count" : "R10 retry saturation",
            retryCount, (k < 7) ? k : 7);
    end
    drain("R2 drain after retries");
    check(remapLane == 5'd31, "R6 no remap on transient", remapLane, 31);
    check(remapCount == 0, "R6 remap count", remapCount, 0);

    // hard fault on data lane 7
    doReset();
    feedEn = 1;
    tick(20);
    stuck1 = 20'h1 << 7;
    waitFor(0);
    check(remapLane == 5'd7, "R5 lane swap", remapLane, 7);
    check(remapCount == 1, "R5 swap count", remapCount, 1);
    feedEn = 1;
    tick(200);
    drain("R2 drain after swap");

    // second hard fault while spare in use
    feedEn = 1;
    stuck1 = stuck1 | (20'h1 << 12);
    waitFor(1);
    check(linkFatal == 1, "R8 second fault fatal", linkFatal, 1);
    check(remapLane == 5'd7, "R8 swap kept", remapLane, 7);
    for (int i = 0; i < 30; i++) begin
      tick(1);
      check(!rxValid && !inReady && txKind == 2'd0, "R7 quiet when fatal",
            {rxValid, inReady, txKind}, 0);
    end

    // two lanes broken together
    doReset();
    monOn = 0;
    stuck0 = (20'h1 << 2) | (20'h1 << 9);
    feedEn = 1;
    waitFor(1);
    check(linkFatal == 1, "R7 two lanes fatal", linkFatal, 1);
    check(remapLane == 5'd31, "R7 no swap", remapLane, 31);
    check(remapCount == 0, "R7 swap count", remapCount, 0);
    tick(5);
    check(!rxValid && !inReady, "R7 stopped", {rxValid, inReady}, 0);

    // parity lane fault
    doReset();
    monOn = 1;
    feedEn = 1;
    tick(10);
    stuck0 = 20'h1 << 18;
    waitFor(0);
    check(remapLane == 5'd18, "R5 parity lane swap", remapLane, 18);
    feedEn = 1;
    tick(150);
    drain("R2 drain after parity swap");
    check(linkFatal == 0, "R5 link healthy", linkFatal, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule